// File: doc/BRIEF.md
# I2C Four-Pin GPIO Expander Register Interface

This block is an I2C-bus target that controls a small general-purpose I/O port. An I2C controller addresses it at a fixed 7-bit address. In a write transaction, the first byte after the address is a command byte. That byte loads a register pointer, and any further bytes in the transaction are written to the register the pointer selects. A read transaction returns the selected register as many times as the controller asks. The pointer never advances on its own.

There are four byte-wide registers behind the pointer:

- the sampled pin levels, with optional per-pin inversion;
- the output latch;
- the inversion mask;
- the direction mask.

Each pin has an output-enable and an output-data signal for an external pad driver. The pad returns its level on a pin input. SCL and SDA are sampled with a fast system clock through synchronizers. SDA is driven open-drain, through a single pull-low enable.

Top module: `gpx_i2c_port`

## Requirements
- R1: The target acknowledges an address byte whose upper 7 bits equal parameter `DEV_ADDR` and pulls SDA low in that ninth clock. For any other address it leaves SDA released in the ninth clock, and it ignores the rest of the transaction until the next START.
- R2: In a write, the first byte after the address loads the pointer from its two low bits (0 input view, 1 output latch, 2 inversion mask, 3 direction mask). Its upper six bits are ignored. The pointer holds until the next command byte, so repeated reads return the same register.
- R3: Register 0 reads as all ones in bits 7..4, and as the synchronized pin levels XOR the inversion mask in bits 3..0. A write to it is acknowledged and changes no register.
- R4: Register 1 reads back the stored output latch in bits 3..0, not the pin levels, with ones in bits 7..4. Its reset value is 0xFF.
- R5: Register 2 holds the inversion mask in bits 3..0, and a 1 inverts the matching input bit. Bits 7..4 read 0, whatever was written. Its reset value is 0x00.
- R6: Register 3 holds the direction mask in bits 3..0, with ones in bits 7..4. A 1 makes the pin an input: its output-enable is low. A 0 enables the pin's driver, which then drives the matching output-latch bit. Its reset value is 0xFF, so all pins start as inputs.
- R7: While `rst_n` is low, all registers hold their defaults, the pointer is 0 and SDA is released. After release, a read with no command byte returns register 0.
- R8: A repeated START restarts address reception but keeps the pointer. A command byte, then a repeated START, then a read returns the selected register.
- R9: Several data bytes in one write all go to the same register, and the last one is kept.
- R10: In a read, a controller ACK makes the target send the selected register again. A controller NACK makes it release SDA and go idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low |
| pin_i | input | NPIO | Levels seen on the I/O pins |
| pin_oe_o | output | NPIO | Per-pin output-driver enable, active high |
| pin_o | output | NPIO | Per-pin value to drive when enabled |

## Verification
The bench builds the block with `DEV_ADDR` set to 7'h2C, so that it differs from the default, and keeps the default `NPIO` of 4 and two synchronizer stages. With four pins, the fixed upper nibble of every register can be observed. The bench probes it by writing values whose upper bits are set and reading them back. The inversion mask is checked over pin patterns that are both inverted and left alone. A wrong-address sequence, repeated START, burst reads and a mid-run reset exercise the pointer's persistence and the bus state machine's exit paths.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int BYTE_W = 8;
   localparam int PTR_W  = 2;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_WACK,
      ST_TX,
      ST_RACK
   } bus_st_t;

   typedef enum logic [PTR_W-1:0] {
      SEL_PINS = 2'd0,
      SEL_OUT  = 2'd1,
      SEL_INV  = 2'd2,
      SEL_DIR  = 2'd3
   } reg_sel_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_BIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin : p_param_chk
      assert (W >= 1 && STAGES >= 0 && STAGES <= 4)
         else $error("gpx_sync: bad W or STAGES");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= {W{RST_BIT}};
            end else begin
               stg_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign q_o = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpx_bus_target.sv
module gpx_bus_target
   import gpx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h49
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s_i,
   input  logic              sda_s_i,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              ptr_wr_o,
   output logic              reg_wr_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic              sda_pull_o
);
   bus_st_t           st_q;
   logic [CNT_W-1:0]  bit_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] tx_q;
   logic              rw_q;
   logic              cmd_q;
   logic              nack_q;
   logic              scl_d_q;
   logic              sda_d_q;

   logic scl_rise, scl_fall, start_det, stop_det, byte_in_done;

   assign scl_rise     = scl_s_i && !scl_d_q;
   assign scl_fall     = !scl_s_i && scl_d_q;
   assign start_det    = scl_s_i && scl_d_q && sda_d_q && !sda_s_i;
   assign stop_det     = scl_s_i && scl_d_q && !sda_d_q && sda_s_i;
   assign byte_in_done = scl_fall && (bit_q == CNT_W'(BYTE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d_q <= 1'b1;
         sda_d_q <= 1'b1;
      end else begin
         scl_d_q <= scl_s_i;
         sda_d_q <= sda_s_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bit_q  <= '0;
         sh_q   <= '0;
         tx_q   <= '0;
         rw_q   <= 1'b0;
         cmd_q  <= 1'b0;
         nack_q <= 1'b0;
      end else if (start_det) begin
         st_q  <= ST_ADDR;
         bit_q <= '0;
         cmd_q <= 1'b1;
      end else if (stop_det) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_ADDR: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
                  bit_q <= bit_q + 1'b1;
               end else if (byte_in_done) begin
                  bit_q <= '0;
                  if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                     st_q <= ST_AACK;
                     rw_q <= sh_q[0];
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  if (rw_q) begin
                     st_q <= ST_TX;
                     tx_q <= rd_data_i;
                  end else begin
                     st_q <= ST_RX;
                  end
               end
            end
            ST_RX: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
                  bit_q <= bit_q + 1'b1;
               end else if (byte_in_done) begin
                  bit_q <= '0;
                  st_q  <= ST_WACK;
                  cmd_q <= 1'b0;
               end
            end
            ST_WACK: begin
               if (scl_fall) st_q <= ST_RX;
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_q == CNT_W'(BYTE_W - 1)) begin
                     bit_q <= '0;
                     st_q  <= ST_RACK;
                  end else begin
                     tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nack_q <= sda_s_i;
               end else if (scl_fall) begin
                  if (!nack_q) begin
                     st_q <= ST_TX;
                     tx_q <= rd_data_i;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ptr_wr_o   = (st_q == ST_RX) && byte_in_done && cmd_q && !start_det && !stop_det;
   assign reg_wr_o   = (st_q == ST_RX) && byte_in_done && !cmd_q && !start_det && !stop_det;
   assign wr_data_o  = sh_q;
   assign sda_pull_o = (st_q == ST_AACK) || (st_q == ST_WACK) ||
                       ((st_q == ST_TX) && !tx_q[BYTE_W-1]);

   AST_NACK_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ADDR && byte_in_done && !start_det && !stop_det &&
       sh_q[BYTE_W-1:1] != DEV_ADDR) |=> !sda_pull_o) else $error("foreign address acknowledged"); // R1

   AST_ACK_EVERY_WRITE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RX && byte_in_done && !start_det && !stop_det) |=> sda_pull_o)
      else $error("write byte not acknowledged"); // R3

   AST_RELEASE_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RACK && scl_fall && nack_q && !start_det && !stop_det) |=> !sda_pull_o)
      else $error("SDA held after controller NACK"); // R10
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
#(
   parameter int NPIO = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr_i,
   input  logic              reg_wr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic [NPIO-1:0]   pin_s_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic [NPIO-1:0]   pin_oe_o,
   output logic [NPIO-1:0]   pin_o
);
   reg_sel_t        ptr_q;
   logic [NPIO-1:0] out_q;
   logic [NPIO-1:0] inv_q;
   logic [NPIO-1:0] dir_q;
   logic            unused_wr_bits;

   assign unused_wr_bits = ^wr_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= SEL_PINS;
         out_q <= '1;
         inv_q <= '0;
         dir_q <= '1;
      end else begin
         if (ptr_wr_i) ptr_q <= reg_sel_t'(wr_data_i[PTR_W-1:0]);
         if (reg_wr_i) begin
            unique case (ptr_q)
               SEL_OUT:  out_q <= wr_data_i[NPIO-1:0];
               SEL_INV:  inv_q <= wr_data_i[NPIO-1:0];
               SEL_DIR:  dir_q <= wr_data_i[NPIO-1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (ptr_q)
         SEL_PINS: begin
            rd_data_o             = '1;
            rd_data_o[NPIO-1:0]   = pin_s_i ^ inv_q;
         end
         SEL_OUT: begin
            rd_data_o             = '1;
            rd_data_o[NPIO-1:0]   = out_q;
         end
         SEL_INV: begin
            rd_data_o             = '0;
            rd_data_o[NPIO-1:0]   = inv_q;
         end
         default: begin
            rd_data_o             = '1;
            rd_data_o[NPIO-1:0]   = dir_q;
         end
      endcase
   end

   assign pin_oe_o = ~dir_q;
   assign pin_o    = out_q;

   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_wr_i |=> $stable(ptr_q)) else $error("pointer moved without command"); // R2

   AST_PIN_VIEW_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && ptr_q == SEL_PINS) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)))
      else $error("write to pin view changed state"); // R3
endmodule

// File: rtl/gpx_i2c_port.sv
module gpx_i2c_port
   import gpx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h49,
   parameter int         NPIO        = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_pull_o,
   input  logic [NPIO-1:0] pin_i,
   output logic [NPIO-1:0] pin_oe_o,
   output logic [NPIO-1:0] pin_o
);
   initial begin : p_param_chk
      assert (NPIO >= 1 && NPIO <= BYTE_W) else $error("gpx_i2c_port: NPIO out of range");
      assert (SYNC_STAGES >= 1) else $error("gpx_i2c_port: bus inputs need a synchronizer");
   end

   logic [1:0]        bus_s;
   logic [NPIO-1:0]   pin_s;
   logic [BYTE_W-1:0] rd_data;
   logic [BYTE_W-1:0] wr_data;
   logic              ptr_wr;
   logic              reg_wr;

   gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (bus_s)
   );

   gpx_sync #(.W(NPIO), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   gpx_bus_target #(.DEV_ADDR(DEV_ADDR)) u_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s_i    (bus_s[1]),
      .sda_s_i    (bus_s[0]),
      .rd_data_i  (rd_data),
      .ptr_wr_o   (ptr_wr),
      .reg_wr_o   (reg_wr),
      .wr_data_o  (wr_data),
      .sda_pull_o (sda_pull_o)
   );

   gpx_regs #(.NPIO(NPIO)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_wr_i  (ptr_wr),
      .reg_wr_i  (reg_wr),
      .wr_data_i (wr_data),
      .pin_s_i   (pin_s),
      .rd_data_o (rd_data),
      .pin_oe_o  (pin_oe_o),
      .pin_o     (pin_o)
   );

   AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !sda_pull_o) else $error("SDA pulled right after reset"); // R7
endmodule

// File: tb/gpx_i2c_port_test.sv
`timescale 1ns/1ps
module gpx_i2c_port_test;
   localparam logic [6:0] ADDR = 7'h2C;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [3:0] pins = 4'h0;
   logic       sda_pull;
   logic [3:0] pin_oe, pin_q;
   logic       sda_bus;
   int         n_chk = 0;
   int         n_bad = 0;
   logic       done = 1'b0;

   assign sda_bus = sda_m & ~sda_pull;

   always #10 clk = ~clk;

   gpx_i2c_port #(.DEV_ADDR(ADDR), .NPIO(4), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .pin_i(pins), .pin_oe_o(pin_oe), .pin_o(pin_q)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic waitq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
      sda_m = 1'b0; waitq(Q); scl_m = 1'b0; waitq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q); sda_m = 1'b1; waitq(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; waitq(Q); scl_m = 1'b1; waitq(2*Q); scl_m = 1'b0; waitq(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q); b = sda_bus;
      waitq(Q); scl_m = 1'b0; waitq(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = !b;
   endtask

   task automatic recv_byte(input logic ctl_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!ctl_ack);
   endtask

   task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d, input string tag);
      logic a;
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk({tag, " addr ack"}, {7'd0, a}, 8'd1);
      send_byte(cmd, a);          chk({tag, " cmd ack"},  {7'd0, a}, 8'd1);
      send_byte(d, a);            chk({tag, " data ack"}, {7'd0, a}, 8'd1);
      bus_stop();
   endtask

   task automatic set_ptr(input logic [7:0] cmd);
      logic a;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(cmd, a);
      bus_stop();
   endtask

   task automatic rd_cur(output logic [7:0] v);
      logic a;
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      recv_byte(1'b0, v);
      bus_stop();
   endtask

   task automatic t_reset_state();
      waitq(3);
      chk("R7 oe in reset", {4'h0, pin_oe}, 8'h00);
      chk("R7 sda in reset", {7'd0, sda_pull}, 8'h00);
      rst_n = 1'b1; waitq(4);
      chk("R6 oe after reset", {4'h0, pin_oe}, 8'h00);
      chk("R4 out after reset", {4'h0, pin_q}, 8'h0F);
   endtask

   task automatic t_defaults();
      logic [7:0] v;
      pins = 4'h9; waitq(8);
      rd_cur(v); chk("R7 default pointer is pin view", v, 8'hF9);
      set_ptr(8'h01); rd_cur(v); chk("R4 output latch reset", v, 8'hFF);
      set_ptr(8'h02); rd_cur(v); chk("R5 inversion reset", v, 8'h00);
      set_ptr(8'h03); rd_cur(v); chk("R6 direction reset", v, 8'hFF);
   endtask

   task automatic t_foreign_addr();
      logic a;
      logic [7:0] v;
      bus_start();
      send_byte({ADDR ^ 7'h01, 1'b0}, a);
      chk("R1 foreign address nacked", {7'd0, a}, 8'd0);
      send_byte(8'h01, a);
      send_byte(8'h00, a);
      bus_stop();
      set_ptr(8'h01); rd_cur(v);
      chk("R1 foreign write ignored", v, 8'hFF);
   endtask

   task automatic t_direction();
      logic [7:0] v;
      wr_reg(8'h01, 8'hA3, "R6");
      wr_reg(8'h03, 8'hFA, "R6");
      chk("R6 oe from direction mask", {4'h0, pin_oe}, 8'h05);
      chk("R6 driven value", {4'h0, pin_q}, 8'h03);
      rd_cur(v); chk("R6 direction readback", v, 8'hFA);
   endtask

   task automatic t_out_readback();
      logic [7:0] v;
      pins = 4'hC; waitq(8);
      set_ptr(8'h01); rd_cur(v);
      chk("R4 latch not pins", v, 8'hF3);
   endtask

   task automatic t_inversion();
      logic [7:0] v;
      pins = 4'hA; waitq(8);
      set_ptr(8'h00); rd_cur(v); chk("R3 pins no inversion", v, 8'hFA);
      wr_reg(8'h02, 8'hF6, "R5");
      rd_cur(v); chk("R5 upper bits read zero", v, 8'h06);
      set_ptr(8'hFC); rd_cur(v); chk("R2 cmd upper bits ignored, R3 inverted", v, 8'hFC);
      rd_cur(v); chk("R2 second read same register", v, 8'hFC);
      pins = 4'h5; waitq(8);
      rd_cur(v); chk("R3 pins follow input", v, 8'hF3);
   endtask

   task automatic t_pin_view_write();
      logic [7:0] v;
      wr_reg(8'h00, 8'h00, "R3");
      set_ptr(8'h01); rd_cur(v); chk("R3 out unchanged", v, 8'hF3);
      set_ptr(8'h02); rd_cur(v); chk("R3 inv unchanged", v, 8'h06);
      set_ptr(8'h03); rd_cur(v); chk("R3 dir unchanged", v, 8'hFA);
   endtask

   task automatic t_multi_write();
      logic a;
      logic [7:0] v;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h01, a);
      send_byte(8'h01, a);
      send_byte(8'h09, a);
      chk("R9 second data acked", {7'd0, a}, 8'd1);
      bus_stop();
      rd_cur(v); chk("R9 last byte kept in same register", v, 8'hF9);
      set_ptr(8'h02); rd_cur(v); chk("R9 next register untouched", v, 8'h06);
   endtask

   task automatic t_rep_start();
      logic a;
      logic [7:0] v;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h03, a);
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      chk("R8 address acked after repeated start", {7'd0, a}, 8'd1);
      recv_byte(1'b0, v);
      bus_stop();
      chk("R8 selected register after repeated start", v, 8'hFA);
   endtask

   task automatic t_burst();
      logic a;
      logic [7:0] v0, v1, v2;
      set_ptr(8'h01);
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      recv_byte(1'b1, v0);
      recv_byte(1'b1, v1);
      recv_byte(1'b0, v2);
      chk("R10 burst byte 0", v0, 8'hF9);
      chk("R10 burst byte 1 same register", v1, 8'hF9);
      chk("R10 burst byte 2 same register", v2, 8'hF9);
      chk("R10 released after nack", {7'd0, sda_pull}, 8'h00);
      bus_stop();
   endtask

   task automatic t_reset_mid();
      logic a;
      logic [7:0] v;
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      sda_m = 1'b0; waitq(Q);
      rst_n = 1'b0; waitq(4);
      chk("R7 oe cleared in reset", {4'h0, pin_oe}, 8'h00);
      chk("R7 out back to ones", {4'h0, pin_q}, 8'h0F);
      chk("R7 sda released", {7'd0, sda_pull}, 8'h00);
      rst_n = 1'b1; sda_m = 1'b1; waitq(Q);
      bus_stop();
      pins = 4'h6; waitq(8);
      rd_cur(v); chk("R7 pointer back to pin view", v, 8'hF6);
      set_ptr(8'h02); rd_cur(v); chk("R7 inversion cleared", v, 8'h00);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      t_reset_state();
      t_defaults();
      t_foreign_addr();
      t_direction();
      t_out_readback();
      t_inversion();
      t_pin_view_write();
      t_multi_write();
      t_rep_start();
      t_burst();
      t_reset_mid();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule